// File: doc/BRIEF.md
# Configurable Multiply-Accumulate Arithmetic Slice

This block is a fixed-function arithmetic slice for signal-processing datapaths. It receives two packed operand buses, each holding up to eight signed lanes. A static mode input selects how the slice treats those lanes. It can run as a bank of independent multipliers at three operand widths: eight narrow, four medium or one wide. It can also run as two multiply-accumulators, as two product adder/subtractors, or as a four-product summation that serves as one filter tap. A complex product is formed in accumulate mode: one adder is set to subtract and the other to add, and the clear is asserted on every item.

Operands are captured in an input register stage. A compile-time option places a register between the multiplier array and the adder stage. Every result leaves through an output register together with a valid flag. The multiplier array holds eight narrow multipliers and four medium ones with one extra bit each. The medium multipliers also produce the single wide product: they form four signed and unsigned partial products, which are then shifted and summed. Narrow operands can use the adder modes by sign-extending each one into its medium lane.

Top module: `dsp_arith_slice`

## Requirements
- R1: After synchronous reset, `res_vld` is 0 and `res` is all zeros.
- R2: Mode 3'd0: for each i in 0..7, the signed product of `op_a[9i+8:9i]` and `op_b[9i+8:9i]` appears in `res[18i+17:18i]`. This includes the case where both lanes hold -256.
- R3: Mode 3'd2: the signed 36x36 product of `op_a[35:0]` and `op_b[35:0]` is 72 bits wide and appears sign-extended across all 144 bits of `res`. This includes the case where both operands hold -2^35.
- R4: Mode 3'd1: for each k in 0..3, the signed product of the 18-bit lanes `op_a[18k+17:18k]` and `op_b[18k+17:18k]` appears in `res[36k+35:36k]`.
- R5: Mode 3'd3: two 52-bit accumulators. Accumulator k adds the term formed from 18-bit lane products p(2k) and p(2k+1). `sub_sel[k]`=0 makes the term p(2k)+p(2k+1), and 1 makes it p(2k)-p(2k+1). The new value of accumulator k appears sign-extended in `res[72k+71:72k]`. The accumulators change only on valid items in this mode.
- R6: When `acc_clr` is 1 on a valid mode-3'd3 item, each accumulator loads that item's term in place of its held value plus the term.
- R7: Accumulator arithmetic wraps modulo 2^52.
- R8: Mode 3'd4: `res[71:0]` holds the sign-extended value of p0±p1, and `res[143:72]` holds the sign-extended value of p2±p3. The operator for each pair is chosen by `sub_sel[0]` and `sub_sel[1]` with the same encoding as R5.
- R9: Mode 3'd5: (p0±p1)+(p2±p3), using the `sub_sel` encoding of R5, appears sign-extended across all 144 bits of `res`.
- R10: Mode codes 3'd6 and 3'd7 produce a valid all-zero result.
- R11: An item presented with `in_vld`=1 produces exactly one result with `res_vld`=1. With `PIPE`=1 the result appears after three clock edges, and with `PIPE`=0 it appears after two. `res` changes only when a result is valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 3 | Static operating mode code |
| sub_sel | input | 2 | Per-adder select: 0 sum, 1 first minus second |
| in_vld | input | 1 | Operand item valid |
| acc_clr | input | 1 | Load accumulators with the item's term |
| op_a | input | 8*NARROW_W | Packed signed operand lanes A |
| op_b | input | 8*NARROW_W | Packed signed operand lanes B |
| res | output | 16*NARROW_W | Packed sign-extended results |
| res_vld | output | 1 | Result valid |

## Verification
Several properties are checked on every cycle:
- The output valid flag follows the valid flag entering the adder stage by exactly one register.
- The accumulators stay unchanged whenever no accumulate item arrives.
- A summation-mode result is a proper sign extension above its 38 significant bits.
- The two unused mode codes yield zeros.
- A wide product of two nonzero operands carries the sign of the operand signs' exclusive-or.

Only the bench scenarios can show the exact values. These cover every packing layout, the clear and wrap behaviour of the accumulators, the sum and difference selections, the most negative operands and the exact cycle on which a result emerges.

// File: rtl/dsp_slice_pkg.sv
package dsp_slice_pkg;
   localparam int NUM_LANES = 8;
   localparam logic [2:0] MD_MUL_NARROW = 3'd0;
   localparam logic [2:0] MD_MUL_MID    = 3'd1;
   localparam logic [2:0] MD_MUL_WIDE   = 3'd2;
   localparam logic [2:0] MD_MAC        = 3'd3;
   localparam logic [2:0] MD_PAIR       = 3'd4;
   localparam logic [2:0] MD_QUAD       = 3'd5;
endpackage

// File: rtl/dsp_mul_array.sv
module dsp_mul_array
   import dsp_slice_pkg::*;
#(
   parameter int NARROW_W = 9
) (
   input  logic [2:0]                     mode,
   input  logic [NUM_LANES*NARROW_W-1:0]  op_a,
   input  logic [NUM_LANES*NARROW_W-1:0]  op_b,
   output logic [16*NARROW_W-1:0]         pn_bus,
   output logic [16*NARROW_W-1:0]         pm_bus,
   output logic [8*NARROW_W-1:0]          pw
);
   localparam int N  = NARROW_W;
   localparam int M  = 2 * N;      // medium operand width
   localparam int ME = M + 1;      // medium multiplier input width
   localparam int PN = 2 * N;      // narrow product width
   localparam int PM = 2 * M;      // medium product width
   localparam int PR = 2 * ME;     // raw medium multiplier output width
   localparam int PW = 4 * M;      // wide product width

   // Narrow lane multipliers
   for (genvar g = 0; g < NUM_LANES; g++) begin : g_nar
      logic [PN-1:0] xa, xb;
      assign xa = {{N{op_a[g*N+N-1]}}, op_a[g*N +: N]};
      assign xb = {{N{op_b[g*N+N-1]}}, op_b[g*N +: N]};
      assign pn_bus[g*PN +: PN] = xa * xb;
   end

   // Medium multipliers, re-used as partial products of the wide product
   logic [PR-1:0] raw [4];
   logic [PW-1:0] wx  [4];

   for (genvar k = 0; k < 4; k++) begin : g_mid
      logic [ME-1:0] ua, ub;
      always_comb begin
         if (mode == MD_MUL_WIDE) begin
            ua = (k % 2 == 1) ? {op_a[2*M-1], op_a[2*M-1:M]} : {1'b0, op_a[M-1:0]};
            ub = (k >= 2)     ? {op_b[2*M-1], op_b[2*M-1:M]} : {1'b0, op_b[M-1:0]};
         end else begin
            ua = {op_a[k*M+M-1], op_a[k*M +: M]};
            ub = {op_b[k*M+M-1], op_b[k*M +: M]};
         end
      end
      assign raw[k] = {{ME{ua[ME-1]}}, ua} * {{ME{ub[ME-1]}}, ub};
      assign pm_bus[k*PM +: PM] = raw[k][PM-1:0];
      assign wx[k] = {{(PW-PR){raw[k][PR-1]}}, raw[k]};
   end

   assign pw = (wx[3] << PM) + ((wx[1] + wx[2]) << M) + wx[0];

   always_comb begin
      if (mode == MD_MUL_WIDE && op_a[PM-1:0] != '0 && op_b[PM-1:0] != '0)
         assert_wide_sign_R3: assert (pw[PW-1] == (op_a[PM-1] ^ op_b[PM-1]))
            else $error("wide product sign mismatch");
   end
endmodule

// File: rtl/dsp_add_stage.sv
module dsp_add_stage
   import dsp_slice_pkg::*;
#(
   parameter int NARROW_W = 9,
   parameter int ACC_HEAD = 16
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic [2:0]             mode,
   input  logic [1:0]             sub_sel,
   input  logic                   vld,
   input  logic                   clr,
   input  logic [16*NARROW_W-1:0] pn_bus,
   input  logic [16*NARROW_W-1:0] pm_bus,
   input  logic [8*NARROW_W-1:0]  pw,
   output logic [16*NARROW_W-1:0] res_d
);
   localparam int N  = NARROW_W;
   localparam int PM = 4 * N;          // medium product width
   localparam int SW = PM + 1;         // pair sum width
   localparam int QW = PM + 2;         // quad sum width
   localparam int AW = PM + ACC_HEAD;  // accumulator width
   localparam int PW = 8 * N;
   localparam int RW = 16 * N;
   localparam int HW = RW / 2;

   logic [SW-1:0] ex [4];
   for (genvar k = 0; k < 4; k++) begin : g_ext
      assign ex[k] = {pm_bus[k*PM+PM-1], pm_bus[k*PM +: PM]};
   end

   logic [SW-1:0] s0, s1;
   logic [QW-1:0] q;
   assign s0 = sub_sel[0] ? (ex[0] - ex[1]) : (ex[0] + ex[1]);
   assign s1 = sub_sel[1] ? (ex[2] - ex[3]) : (ex[2] + ex[3]);
   assign q  = {s0[SW-1], s0} + {s1[SW-1], s1};

   logic [AW-1:0] t0, t1, acc0_q, acc1_q, acc0_n, acc1_n;
   assign t0 = {{(AW-SW){s0[SW-1]}}, s0};
   assign t1 = {{(AW-SW){s1[SW-1]}}, s1};
   assign acc0_n = clr ? t0 : (acc0_q + t0);
   assign acc1_n = clr ? t1 : (acc1_q + t1);

   always_ff @(posedge clk) begin
      if (rst) begin
         acc0_q <= '0;
         acc1_q <= '0;
      end else if (vld && mode == MD_MAC) begin
         acc0_q <= acc0_n;
         acc1_q <= acc1_n;
      end
   end

   always_comb begin
      case (mode)
         MD_MUL_NARROW: res_d = pn_bus;
         MD_MUL_MID:    res_d = pm_bus;
         MD_MUL_WIDE:   res_d = {{(RW-PW){pw[PW-1]}}, pw};
         MD_MAC:        res_d = {{(HW-AW){acc1_n[AW-1]}}, acc1_n,
                                 {(HW-AW){acc0_n[AW-1]}}, acc0_n};
         MD_PAIR:       res_d = {{(HW-SW){s1[SW-1]}}, s1,
                                 {(HW-SW){s0[SW-1]}}, s0};
         MD_QUAD:       res_d = {{(RW-QW){q[QW-1]}}, q};
         default:       res_d = '0;
      endcase
   end

   assert_acc_hold_R5: assert property (@(posedge clk) disable iff (rst)
      !(vld && mode == MD_MAC) |=> ($stable(acc0_q) && $stable(acc1_q)))
      else $error("accumulator moved without an accumulate item");
endmodule

// File: rtl/dsp_arith_slice.sv
module dsp_arith_slice
   import dsp_slice_pkg::*;
#(
   parameter int NARROW_W = 9,
   parameter int ACC_HEAD = 16,
   parameter int PIPE     = 1
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic [2:0]                    mode,
   input  logic [1:0]                    sub_sel,
   input  logic                          in_vld,
   input  logic                          acc_clr,
   input  logic [NUM_LANES*NARROW_W-1:0] op_a,
   input  logic [NUM_LANES*NARROW_W-1:0] op_b,
   output logic [16*NARROW_W-1:0]        res,
   output logic                          res_vld
);
   localparam int LW = NUM_LANES * NARROW_W;
   localparam int RW = 16 * NARROW_W;
   localparam int QW = 4 * NARROW_W + 2;

   if (NARROW_W < 2) begin : g_chk_w
      $error("NARROW_W must be at least 2");
   end
   if (ACC_HEAD < 2 || ACC_HEAD >= 4 * NARROW_W) begin : g_chk_h
      $error("ACC_HEAD out of range");
   end
   if (PIPE != 0 && PIPE != 1) begin : g_chk_p
      $error("PIPE must be 0 or 1");
   end

   // Input register stage
   logic [LW-1:0] a_q, b_q;
   logic          vld_q, clr_q;
   always_ff @(posedge clk) begin
      if (rst) begin
         a_q <= '0; b_q <= '0; vld_q <= 1'b0; clr_q <= 1'b0;
      end else begin
         a_q <= op_a; b_q <= op_b; vld_q <= in_vld; clr_q <= acc_clr;
      end
   end

   logic [RW-1:0] pn_x, pm_x, pn_m, pm_m, res_d;
   logic [LW-1:0] pw_x, pw_m;
   logic          vld_m, clr_m;

   dsp_mul_array #(.NARROW_W(NARROW_W)) u_mul (
      .mode(mode), .op_a(a_q), .op_b(b_q),
      .pn_bus(pn_x), .pm_bus(pm_x), .pw(pw_x)
   );

   if (PIPE == 1) begin : g_pipe
      always_ff @(posedge clk) begin
         if (rst) begin
            pn_m <= '0; pm_m <= '0; pw_m <= '0; vld_m <= 1'b0; clr_m <= 1'b0;
         end else begin
            pn_m <= pn_x; pm_m <= pm_x; pw_m <= pw_x; vld_m <= vld_q; clr_m <= clr_q;
         end
      end
   end else begin : g_bypass
      assign pn_m  = pn_x;
      assign pm_m  = pm_x;
      assign pw_m  = pw_x;
      assign vld_m = vld_q;
      assign clr_m = clr_q;
   end

   dsp_add_stage #(.NARROW_W(NARROW_W), .ACC_HEAD(ACC_HEAD)) u_add (
      .clk(clk), .rst(rst), .mode(mode), .sub_sel(sub_sel),
      .vld(vld_m), .clr(clr_m),
      .pn_bus(pn_m), .pm_bus(pm_m), .pw(pw_m), .res_d(res_d)
   );

   // Output register stage
   always_ff @(posedge clk) begin
      if (rst) begin
         res <= '0; res_vld <= 1'b0;
      end else begin
         res_vld <= vld_m;
         if (vld_m) res <= res_d;
      end
   end

   assert_vld_follow_R11: assert property (@(posedge clk) disable iff (rst)
      res_vld == $past(vld_m))
      else $error("result valid out of step");

   assert_quad_sext_R9: assert property (@(posedge clk) disable iff (rst)
      (res_vld && mode == MD_QUAD) |->
         ((&res[RW-1:QW-1]) || (res[RW-1:QW-1] == '0)))
      else $error("summation result not sign-extended");

   assert_unused_zero_R10: assert property (@(posedge clk) disable iff (rst)
      (res_vld && mode > MD_QUAD) |-> (res == '0))
      else $error("unused mode gave nonzero result");
endmodule

// File: tb/dsp_arith_slice_tb_top.sv
`timescale 1ns/1ps
module dsp_arith_slice_tb_top;
   localparam int PIPE_TB = 1;
   localparam int LAT     = (PIPE_TB == 1) ? 3 : 2;

   logic         clk = 1'b0;
   logic         rst;
   logic [2:0]   mode;
   logic [1:0]   sub_sel;
   logic         in_vld, acc_clr;
   logic [71:0]  op_a, op_b;
   logic [143:0] res;
   logic         res_vld;

   int checks = 0;
   int fails  = 0;

   logic [143:0] exp_q [$];
   string        tag_q [$];
   logic [51:0]  acc0_m = '0, acc1_m = '0;

   always #10 clk = ~clk;

   dsp_arith_slice #(.NARROW_W(9), .ACC_HEAD(16), .PIPE(PIPE_TB)) dut_i (
      .clk(clk), .rst(rst), .mode(mode), .sub_sel(sub_sel),
      .in_vld(in_vld), .acc_clr(acc_clr), .op_a(op_a), .op_b(op_b),
      .res(res), .res_vld(res_vld)
   );

   task automatic chk(input bit ok, input string tag,
                      input logic [143:0] act, input logic [143:0] expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, expv);
      end
   endtask

   function automatic logic signed [143:0] fld(input logic [71:0] v, input int lo, input int w);
      logic signed [143:0] t;
      t = $signed({72'b0, v >> lo});
      t = t <<< (144 - w);
      return t >>> (144 - w);
   endfunction

   function automatic logic [71:0] rnd72();
      logic [95:0] t;
      t = {$urandom(), $urandom(), $urandom()};
      return t[71:0];
   endfunction

   // Driver: computes the expected result and queues it
   task automatic drive(input logic [71:0] a, input logic [71:0] b,
                        input logic clr, input string tag);
      logic [143:0]        e;
      logic signed [143:0] pp, s0, s1, x0, x1;
      logic signed [143:0] p [4];
      e = '0;
      for (int k = 0; k < 4; k++) p[k] = fld(a, 18*k, 18) * fld(b, 18*k, 18);
      s0 = sub_sel[0] ? (p[0] - p[1]) : (p[0] + p[1]);
      s1 = sub_sel[1] ? (p[2] - p[3]) : (p[2] + p[3]);
      case (mode)
         3'd0: for (int i = 0; i < 8; i++) begin
                  pp = fld(a, 9*i, 9) * fld(b, 9*i, 9);
                  e[18*i +: 18] = pp[17:0];
               end
         3'd1: for (int k = 0; k < 4; k++) e[36*k +: 36] = p[k][35:0];
         3'd2: e = fld(a, 0, 36) * fld(b, 0, 36);
         3'd3: begin
                  acc0_m = clr ? s0[51:0] : (acc0_m + s0[51:0]);
                  acc1_m = clr ? s1[51:0] : (acc1_m + s1[51:0]);
                  x0 = fld({20'b0, acc0_m}, 0, 52);
                  x1 = fld({20'b0, acc1_m}, 0, 52);
                  e = {x1[71:0], x0[71:0]};
               end
         3'd4: e = {s1[71:0], s0[71:0]};
         3'd5: e = s0 + s1;
         default: e = '0;
      endcase
      @(negedge clk);
      op_a = a; op_b = b; acc_clr = clr; in_vld = 1'b1;
      exp_q.push_back(e);
      tag_q.push_back(tag);
   endtask

   task automatic idle(input int n);
      @(negedge clk);
      in_vld = 1'b0; acc_clr = 1'b0;
      repeat (n - 1) @(negedge clk);
   endtask

   task automatic set_mode(input logic [2:0] m, input logic [1:0] s);
      idle(6);
      mode = m; sub_sel = s;
   endtask

   // Monitor: pops and compares results as they appear
   always @(negedge clk) begin
      if (!rst && res_vld) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R11 unexpected result", res, '0);
         end else begin
            logic [143:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(res === e, t, res, e);
         end
      end
   end

   // Watchdog
   initial begin
      repeat (180000) @(posedge clk);
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   localparam logic [71:0] NEG9  = {8{9'h100}};
   localparam logic [71:0] NEG18 = {4{18'h20000}};
   localparam logic [71:0] NEG36 = {36'h0, 36'h8_0000_0000};
   localparam logic [71:0] POS18 = {4{18'h1FFFF}};

   initial begin
      rst = 1'b1; mode = 3'd0; sub_sel = 2'b00;
      in_vld = 1'b0; acc_clr = 1'b0; op_a = '0; op_b = '0;
      repeat (4) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk(res_vld == 1'b0, "R1 valid after reset", {143'b0, res_vld}, '0);
      chk(res == '0, "R1 result after reset", res, '0);

      // R2 eight narrow products
      set_mode(3'd0, 2'b00);
      drive(NEG9, NEG9, 1'b0, "R2 most negative");
      drive(NEG9, {8{9'h0FF}}, 1'b0, "R2 min times max");
      for (int i = 0; i < 40; i++) drive(rnd72(), rnd72(), 1'b0, "R2 random");

      // R4 four medium products
      set_mode(3'd1, 2'b00);
      drive(NEG18, NEG18, 1'b0, "R4 most negative");
      drive(NEG18, POS18, 1'b0, "R4 min times max");
      for (int i = 0; i < 40; i++) drive(rnd72(), rnd72(), 1'b0, "R4 random");

      // R3 wide product
      set_mode(3'd2, 2'b00);
      drive(NEG36, NEG36, 1'b0, "R3 most negative");
      drive(NEG36, {36'h0, 36'h7_FFFF_FFFF}, 1'b0, "R3 min times max");
      drive({36'h0, 36'hF_FFFF_FFFF}, {36'h0, 36'h0_0000_0003}, 1'b0, "R3 minus one");
      for (int i = 0; i < 40; i++) drive(rnd72(), rnd72(), 1'b0, "R3 random");

      // R8 pair adder / subtractor, all selections
      for (int s = 0; s < 4; s++) begin
         set_mode(3'd4, s[1:0]);
         drive(NEG18, NEG18, 1'b0, "R8 most negative");
         for (int i = 0; i < 20; i++) drive(rnd72(), rnd72(), 1'b0, "R8 random");
      end

      // R9 four-product summation
      for (int s = 0; s < 4; s++) begin
         set_mode(3'd5, s[1:0]);
         drive(NEG18, NEG18, 1'b0, "R9 most negative");
         drive(NEG18, POS18, 1'b0, "R9 min times max");
         for (int i = 0; i < 20; i++) drive(rnd72(), rnd72(), 1'b0, "R9 random");
      end

      // R5 and R6 dual accumulators
      for (int s = 0; s < 4; s++) begin
         set_mode(3'd3, s[1:0]);
         drive(rnd72(), rnd72(), 1'b1, "R6 initial clear");
         for (int i = 0; i < 15; i++) drive(rnd72(), rnd72(), 1'b0, "R5 accumulate");
         drive(rnd72(), rnd72(), 1'b1, "R6 clear mid-stream");
         for (int i = 0; i < 10; i++) drive(rnd72(), rnd72(), 1'b0, "R5 accumulate");
      end

      // R5 hold across other modes, then continue accumulating
      set_mode(3'd1, 2'b00);
      for (int i = 0; i < 5; i++) drive(rnd72(), rnd72(), 1'b0, "R4 between accumulations");
      set_mode(3'd3, 2'b11);
      drive(rnd72(), rnd72(), 1'b0, "R5 accumulator held across modes");

      // R10 unused codes
      set_mode(3'd6, 2'b00);
      for (int i = 0; i < 5; i++) drive(rnd72(), rnd72(), 1'b0, "R10 code 6");
      set_mode(3'd7, 2'b11);
      for (int i = 0; i < 5; i++) drive(rnd72(), rnd72(), 1'b0, "R10 code 7");

      // R11 latency count
      set_mode(3'd0, 2'b00);
      drive(rnd72(), rnd72(), 1'b0, "R11 latency item");
      @(negedge clk);
      in_vld = 1'b0;
      chk(res_vld == (LAT == 1), "R11 latency edge 1", {143'b0, res_vld}, {143'b0, LAT == 1});
      for (int n = 2; n <= LAT + 1; n++) begin
         @(negedge clk);
         chk(res_vld == (n == LAT), "R11 latency count", {143'b0, res_vld}, {143'b0, n == LAT});
      end

      // R7 wrap: each term is 2^35, so 2^17 terms wrap the 52-bit accumulator
      set_mode(3'd3, 2'b00);
      for (int i = 0; i < 131076; i++) drive(NEG18, NEG18, i == 0, "R7 wrap");

      idle(10);
      chk(exp_q.size() == 0, "R11 missing results", exp_q.size(), '0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule